// File: doc/BRIEF.md
# Complementary PWM Dead-Time Gate Controller

This block takes a single PWM command and produces a complementary pair of gate enables for a half bridge. `out_a` drives the high-side switch and `out_b` drives the low-side switch. Each time the commanded side changes, the block first switches the conducting side off. It then holds both enables low for a programmable number of clock cycles before it switches the other side on. The two enables are never high together.

Several conditions force the enables off. A shutdown input forces both low. A supply-good flag for the input side also forces both low. Each of the two drivers has its own supply-good flag, and that flag forces only its own enable low. When a supply flag returns, the outputs it controls stay off through a start-up hold-off. After that, they wait through the normal dead time before they switch on. Reset and every forced-off state end the same way: the next turn-on always pays the full dead time.

Top module: `pwm_deadtime_ctrl`

## Requirements
- R1: In steady state, `pwm` = 1 gives `out_a` = 1 and `out_b` = 0, and `pwm` = 0 gives `out_a` = 0 and `out_b` = 1. An output is high only if `pwm` selected its side at the previous clock edge.
- R2: When the requested side changes, the conducting output goes low at the next clock edge. The other output then rises after exactly N cycles with both outputs low. N is `dt_cycles`, except that a value of 0 is raised to the floor `MIN_DT` (default 1).
- R3: `out_a` and `out_b` are never both 1.
- R4: While `shut` = 1, both outputs are 0 from the next clock edge on, whatever `pwm` does. After `shut` returns to 0, the selected output rises only after the full dead time.
- R5: While `in_ok` = 0, both outputs are 0 from the next clock edge on.
- R6: `drv_a_ok` = 0 forces `out_a` to 0 from the next edge on and leaves `out_b` untouched. `drv_b_ok` = 0 does the same for `out_b` only.
- R7: After a supply flag rises, or after reset is released with the flags high, the outputs that flag controls stay low for `HOLD_CYC` cycles. They then switch on after the dead time, so the first rise is seen `HOLD_CYC` + N + 1 cycles after the flag rose. A flag that drops before the hold-off completes restarts the hold-off.
- R8: If `pwm` returns before the dead time has elapsed, the pending turn-on is cancelled and the dead time restarts for the new side. A pulse shorter than the dead time therefore never reaches the opposite output.
- R9: During reset both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm | input | 1 | PWM command, 1 selects the high side |
| shut | input | 1 | Forces both outputs low while high |
| in_ok | input | 1 | Input-side supply good |
| drv_a_ok | input | 1 | High-side driver supply good |
| drv_b_ok | input | 1 | Low-side driver supply good |
| dt_cycles | input | DT_W | Dead time in clock cycles |
| out_a | output | 1 | High-side gate enable |
| out_b | output | 1 | Low-side gate enable |

## Verification
The bench measures the exact cycle of each turn-on after a direction change, including for a programmed dead time of 0. A design that skipped the floor of one cycle would let one enable rise in the same edge the other falls; an off-by-one counter would show up as one cycle too many or too few of both-low. A PWM pulse shorter than the dead time is applied to confirm the opposite side never fires. A driver supply is dropped while the other side conducts, and its flag is bounced during the hold-off to check that the count restarts; a shared or unrestarted counter would switch on too early. Release from shutdown and from an input-side supply loss is timed to catch a turn-on that bypasses the dead time.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;

  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_A    = 2'd1,
    SIDE_B    = 2'd2
  } side_e;

  // Dead time actually applied: the programmed count, raised to a floor.
  function automatic int unsigned dt_floor(input int unsigned dt_req,
                                           input int unsigned min_dt);
    return (dt_req < min_dt) ? min_dt : dt_req;
  endfunction

endpackage

// File: rtl/pwm_dt_holdoff.sv
module pwm_dt_holdoff #(
  parameter int HOLD_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag,
  output logic ready
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] LIMIT = HW'(HOLD_CYC);

  logic [HW-1:0] cnt;
  logic          done;

  assign done = (cnt == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!flag)   cnt <= '0;
    else if (!done)   cnt <= cnt + 1'b1;
  end

  // Drops combinationally with the flag so a lockout acts at the next edge.
  assign ready = flag && done;
endmodule

// File: rtl/pwm_dt_gate.sv
module pwm_dt_gate
  import pwm_dt_pkg::*;
(
  input  logic       pwm,
  input  logic       shut,
  input  logic [2:0] rdy,   // [0] input side, [1] driver A, [2] driver B
  output side_e      req
);
  logic en_a, en_b;

  assign en_a = rdy[0] && rdy[1] && !shut;
  assign en_b = rdy[0] && rdy[2] && !shut;

  always_comb begin
    if (pwm && en_a)       req = SIDE_A;
    else if (!pwm && en_b) req = SIDE_B;
    else                   req = SIDE_NONE;
  end
endmodule

// File: rtl/pwm_dt_core.sv
module pwm_dt_core
  import pwm_dt_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  side_e           req,
  input  logic [DT_W-1:0] dt_eff,
  output logic            out_a,
  output logic            out_b
);
  logic [DT_W-1:0] cnt;
  side_e           pend;
  logic [DT_W:0]   elapsed;
  logic            drop_a, drop_b, both_low, redirect, expired;

  assign both_low = !out_a && !out_b;
  assign drop_a   = out_a && (req != SIDE_A);
  assign drop_b   = out_b && (req != SIDE_B);
  assign redirect = both_low && (req != pend);
  assign elapsed  = {1'b0, cnt} + 1'b1;
  assign expired  = (elapsed >= {1'b0, dt_eff});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_a <= 1'b0;
      out_b <= 1'b0;
      cnt   <= '0;
      pend  <= SIDE_NONE;
    end else if (drop_a || drop_b) begin
      out_a <= 1'b0;
      out_b <= 1'b0;
      pend  <= req;
      cnt   <= '0;
    end else if (redirect) begin
      pend  <= req;
      cnt   <= '0;
    end else if (both_low && pend != SIDE_NONE) begin
      if (expired) begin
        out_a <= (pend == SIDE_A);
        out_b <= (pend == SIDE_B);
        cnt   <= '0;
      end else begin
        cnt <= elapsed[DT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pwm_deadtime_ctrl.sv
module pwm_deadtime_ctrl
  import pwm_dt_pkg::*;
#(
  parameter int DT_W     = 8,
  parameter int HOLD_CYC = 16,
  parameter int MIN_DT   = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm,
  input  logic            shut,
  input  logic            in_ok,
  input  logic            drv_a_ok,
  input  logic            drv_b_ok,
  input  logic [DT_W-1:0] dt_cycles,
  output logic            out_a,
  output logic            out_b
);
  localparam int NFLAG = 3;

  logic [NFLAG-1:0] flags, rdy;
  logic [DT_W-1:0]  dt_eff;
  side_e            req;

  assign flags  = {drv_b_ok, drv_a_ok, in_ok};
  assign dt_eff = DT_W'(dt_floor(32'(dt_cycles), 32'(MIN_DT)));

  for (genvar g = 0; g < NFLAG; g++) begin : g_hold
    pwm_dt_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .flag  (flags[g]),
      .ready (rdy[g])
    );
  end

  pwm_dt_gate u_gate (
    .pwm  (pwm),
    .shut (shut),
    .rdy  (rdy),
    .req  (req)
  );

  pwm_dt_core #(.DT_W(DT_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .dt_eff (dt_eff),
    .out_a  (out_a),
    .out_b  (out_b)
  );
endmodule

// File: rtl/pwm_dt_chk.sv
module pwm_dt_chk
  import pwm_dt_pkg::*;
#(
  parameter int DT_W   = 8,
  parameter int MIN_DT = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pwm,
  input logic            shut,
  input logic            in_ok,
  input logic            drv_a_ok,
  input logic            drv_b_ok,
  input logic [DT_W-1:0] dt_cycles,
  input logic            out_a,
  input logic            out_b
);
  logic [DT_W:0]   low_run;
  logic [DT_W-1:0] dt_q;
  logic [DT_W:0]   need;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '1;
      dt_q    <= '0;
    end else begin
      dt_q <= dt_cycles;
      if (out_a || out_b)    low_run <= '0;
      else if (low_run != '1) low_run <= low_run + 1'b1;
    end
  end

  assign need = (DT_W+1)'(dt_floor(32'(dt_q), 32'(MIN_DT)));

  // R1
  a_side_follows_pwm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_a |-> $past(pwm)) and (out_b |-> !$past(pwm)));

  // R2
  a_dead_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_a) || $rose(out_b)) |-> (low_run >= need));

  // R3
  a_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_a && out_b));

  // R4
  a_shut_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shut |=> (!out_a && !out_b));

  // R5
  a_input_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ok |=> (!out_a && !out_b));

  // R6
  a_drv_a_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_a_ok |=> !out_a);

  // R6
  a_drv_b_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_b_ok |=> !out_b);
endmodule

bind pwm_deadtime_ctrl pwm_dt_chk #(.DT_W(DT_W), .MIN_DT(MIN_DT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwm       (pwm),
  .shut      (shut),
  .in_ok     (in_ok),
  .drv_a_ok  (drv_a_ok),
  .drv_b_ok  (drv_b_ok),
  .dt_cycles (dt_cycles),
  .out_a     (out_a),
  .out_b     (out_b)
);

// File: tb/test_pwm_deadtime_ctrl.sv
module test_pwm_deadtime_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DT_W = 6;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_n, pwm, shut, in_ok, drv_a_ok, drv_b_ok;
  logic [DT_W-1:0] dt_cycles;
  logic out_a, out_b;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_deadtime_ctrl #(.DT_W(DT_W), .HOLD_CYC(HOLD), .MIN_DT(1)) i_pwm_deadtime_ctrl (
    .clk(clk), .rst_n(rst_n), .pwm(pwm), .shut(shut), .in_ok(in_ok),
    .drv_a_ok(drv_a_ok), .drv_b_ok(drv_b_ok), .dt_cycles(dt_cycles),
    .out_a(out_a), .out_b(out_b));

  typedef struct packed {
    logic       pwm;
    logic       shut;
    logic [5:0] dt;
    logic [3:0] cyc;
    logic       ea;
    logic       eb;
  } vec_t;

  // Steady-state vectors: each holds long enough for dead time to elapse.
  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b0, 6'd3, 4'd6, 1'b1, 1'b0},
    '{1'b0, 1'b0, 6'd3, 4'd6, 1'b0, 1'b1},
    '{1'b1, 1'b0, 6'd0, 4'd3, 1'b1, 1'b0},
    '{1'b0, 1'b0, 6'd5, 4'd8, 1'b0, 1'b1},
    '{1'b0, 1'b1, 6'd5, 4'd3, 1'b0, 1'b0},
    '{1'b1, 1'b1, 6'd5, 4'd3, 1'b0, 1'b0},
    '{1'b1, 1'b0, 6'd5, 4'd8, 1'b1, 1'b0},
    '{1'b0, 1'b0, 6'd1, 4'd3, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic ea, input logic eb);
    n_chk++;
    if (out_a !== ea || out_b !== eb) begin
      n_fail++;
      $display("FAIL %s: out_a=%0b out_b=%0b expected out_a=%0b out_b=%0b at %0t",
               req, out_a, out_b, ea, eb, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pwm = 1'b1; shut = 1'b0; in_ok = 1'b1;
    drv_a_ok = 1'b1; drv_b_ok = 1'b1; dt_cycles = 6'd3;
    step(3);
    check("R9 reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    // R7: first rise after HOLD + dead time + 1 cycles
    step(HOLD + 3);
    check("R7 startup still low", 1'b0, 1'b0);
    step(1);
    check("R7 startup rise", 1'b1, 1'b0);

    // R1/R4 steady-state vector walk
    for (int i = 0; i < 8; i++) begin
      pwm = VECS[i].pwm; shut = VECS[i].shut; dt_cycles = VECS[i].dt;
      for (int k = 0; k < int'(VECS[i].cyc); k++) begin
        step(1);
        if (out_a && out_b) check("R3 overlap in vector walk", 1'b0, 1'b0);
      end
      check(VECS[i].shut ? "R4 vector" : "R1 vector", VECS[i].ea, VECS[i].eb);
    end

    // R2: exact dead time of 4, B -> A
    dt_cycles = 6'd4; pwm = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      step(1);
      if (k <= 4) check("R2 both low during dt=4", 1'b0, 1'b0);
      else        check("R2 rise after dt=4", 1'b1, 1'b0);
    end
    // R2: dead time 0 acts as one cycle, A -> B
    dt_cycles = 6'd0; pwm = 1'b0;
    step(1); check("R2 dt=0 one low cycle", 1'b0, 1'b0);
    step(1); check("R2 dt=0 rise", 1'b0, 1'b1);

    // R8: short high pulse never reaches out_a
    dt_cycles = 6'd3; step(2);
    pwm = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      step(1);
      if (k == 2) pwm = 1'b0;
      if (k < 6) check("R8 short pulse suppressed", 1'b0, 1'b0);
      else       check("R8 return after restarted dt", 1'b0, 1'b1);
    end

    // R6: driver B lockout leaves A alone, driver A lockout clears A
    dt_cycles = 6'd2; pwm = 1'b1; step(4);
    check("R6 setup", 1'b1, 1'b0);
    drv_b_ok = 1'b0; step(3);
    check("R6 drv_b drop keeps out_a", 1'b1, 1'b0);
    drv_b_ok = 1'b1;
    drv_a_ok = 1'b0; step(1);
    check("R6 drv_a drop clears out_a", 1'b0, 1'b0);
    // R7: bounced flag restarts the hold-off
    drv_a_ok = 1'b1; step(2);
    drv_a_ok = 1'b0; step(1);
    drv_a_ok = 1'b1;
    step(HOLD + 2);
    check("R7 restarted hold-off still low", 1'b0, 1'b0);
    step(1);
    check("R7 rise after restarted hold-off", 1'b1, 1'b0);

    // R4: shutdown and dead-time-respecting release
    shut = 1'b1; step(1);
    check("R4 shut clears", 1'b0, 1'b0);
    step(2);
    shut = 1'b0; step(2);
    check("R4 release waits dead time", 1'b0, 1'b0);
    step(1);
    check("R4 release rise", 1'b1, 1'b0);

    // R5: input-side supply loss, shut toggles have no visible effect
    in_ok = 1'b0; step(1);
    check("R5 input lockout clears", 1'b0, 1'b0);
    pwm = 1'b0; shut = 1'b1; step(2); shut = 1'b0; step(3);
    check("R5 stays low while lockout", 1'b0, 1'b0);
    in_ok = 1'b1;
    step(HOLD + 2);
    check("R5 R7 restore still low", 1'b0, 1'b0);
    step(1);
    check("R5 R7 restore rise", 1'b0, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule